// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire station management bus used to configure Ethernet PHYs with 32-bit management frames. A processor reaches it through a small 32-bit register port with two words. The control word sets the management clock divider and turns on the optional preamble. Writing the command word starts a frame. The command word is laid out as an exact image of the frame on the wire: start, opcode, PHY address, register address, turnaround and data. The engine can therefore shift it out most significant bit first without reordering any field.

While a frame runs, the block raises a busy flag and produces the management clock from the system clock. The data line is split into output, output-enable and input signals. For a read, the block releases the line for the turnaround and data bits. It gathers the sixteen bits the PHY returns into the low half of the command word, where the processor collects them once busy drops.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0 (divider 0, preamble off, busy clear), and mdc and mdio_oe are low.
- R2: The control word at byte offset 0x000 holds the divider in bits [6:0] and the preamble enable in bit 7, both writable and read back. Bit 8 reports busy and ignores writes. All other bits read 0.
- R3: While busy, mdc toggles once every max(divider,1)+1 system clocks, so each half period is that many clocks. While idle, mdc is low.
- R4: With the preamble enabled, 32 one-bits go out before command bit 31. With it disabled, the frame starts at command bit 31.
- R5: Command bits go out in order from bit 31 down to bit 0, one bit per mdc period. A frame whose opcode (bits [29:28]) is not 10 drives all 32 bits with mdio_oe high.
- R6: mdio_out and mdio_oe change only when mdc falls. mdio_in is sampled when mdc rises.
- R7: For a frame with opcode 10 (read), mdio_oe is low for the last 18 bit times (turnaround bits 17:16 and data bits 15:0). The 16 sampled data bits are shifted into bits [15:0] of the command word, first-received bit ending in bit 15. Bits [31:16] keep the written value.
- R8: A write to byte offset 0x004 while idle sets busy on the next clock. Busy clears, and mdio_oe goes low, at the mdc fall that ends the last bit.
- R9: A write to the command word while busy is set has no effect on the frame in flight or on the command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register byte offset (0x0 control, 0x4 command) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven to the line |
| mdio_oe | output | 1 | High while the block drives the data line |
| mdio_in | input | 1 | Management data received from the line |

## Verification
The assertions check on every cycle that mdc stays low while idle, that the line output and enable hold still while mdc is high, that the line is released when busy drops, and that a command written during busy leaves the command word unchanged. Only the bench scenarios can show the bit order of a whole frame with and without preamble, the exact half-period length at several divider values (including the zero-to-one rule), the release pattern of a read frame, and the assembly of the returned data from a PHY model that answers on the line.

// File: rtl/mdio_pkg.sv
// Package: shared constants for the management master.
// Assumes 32-bit register words and a 32-bit management frame.
package mdio_pkg;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 3;
    localparam int DIV_W      = 7;
    localparam int FRAME_BITS = 32;
    localparam int PRE_BITS   = 32;
    localparam int TA_POS     = 14;   // first released bit time in a read
    localparam int DATA_POS   = 16;   // first sampled bit time in a read
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'h0;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 3'h4;
    localparam logic [1:0] OPC_READ = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
// Module: management clock generator.
// Toggles mdc every max(div,1)+1 clocks while run is high and holds it
// low otherwise. The tick outputs flag the edge at which mdc will change.
module mdio_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;
    logic             tick;

    // Effective limit: a divider of zero behaves as one.
    always_comb lim = (div == '0) ? DIV_W'(1) : div;

    assign tick      = run && (cnt_q >= lim);
    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

    // Phase counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Module: frame serializer.
// Loads the command image (behind an optional preamble) on start and shifts
// it out MSB first, advancing at each mdc fall. Read frames release the
// line from the turnaround on and report the sampled data bits.
// Assumes start is only raised while the engine is idle.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  pre_en,
    input  logic [FRAME_BITS-1:0] cmd,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic                  mdio_in,
    output logic                  active,
    output logic                  mdio_out,
    output logic                  mdio_oe,
    output logic                  smp_valid,
    output logic                  smp_bit
);
    localparam int SH_W  = PRE_BITS + FRAME_BITS;
    localparam int CNT_W = $clog2(SH_W) + 1;

    logic [SH_W-1:0]  sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pre_q;
    logic             rd_q;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] pos;
    logic             in_pre;
    logic             released;

    // Position within the 32-bit frame, past any preamble.
    always_comb begin
        last_idx = pre_q ? CNT_W'(SH_W - 1) : CNT_W'(FRAME_BITS - 1);
        in_pre   = pre_q && (cnt_q < CNT_W'(PRE_BITS));
        pos      = cnt_q - (pre_q ? CNT_W'(PRE_BITS) : CNT_W'(0));
        released = rd_q && !in_pre && (pos >= CNT_W'(TA_POS));
    end

    assign mdio_oe   = active && !released;
    assign mdio_out  = mdio_oe && sh_q[SH_W-1];
    assign smp_valid = active && rise_tick && rd_q && !in_pre &&
                       (pos >= CNT_W'(DATA_POS));
    assign smp_bit   = mdio_in;

    // Frame state: load on start, advance or finish on each mdc fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            pre_q  <= 1'b0;
            rd_q   <= 1'b0;
            active <= 1'b0;
        end else if (start) begin
            sh_q   <= pre_en ? {{PRE_BITS{1'b1}}, cmd} : {cmd, {PRE_BITS{1'b0}}};
            cnt_q  <= '0;
            pre_q  <= pre_en;
            rd_q   <= (cmd[29:28] == OPC_READ);
            active <= 1'b1;
        end else if (active && fall_tick) begin
            if (cnt_q == last_idx) begin
                active <= 1'b0;
            end else begin
                sh_q  <= {sh_q[SH_W-2:0], 1'b0};
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Module: register-mapped management master (top).
// Holds the control and command words, starts frames on command writes
// while idle and collects read data into the low command half.
// Assumes single-cycle register writes and a combinational read port.
module mdio_master
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    logic [DIV_W-1:0] div_q;
    logic             pre_q;
    logic [REG_W-1:0] data_q;
    logic             busy;
    logic             start;
    logic             rise_tick;
    logic             fall_tick;
    logic             smp_valid;
    logic             smp_bit;

    assign start = reg_wr && (reg_addr == OFS_CMD) && !busy;

    // Control word: divider and preamble enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            pre_q <= 1'b0;
        end else if (reg_wr && reg_addr == OFS_CTRL) begin
            div_q <= reg_wdata[DIV_W-1:0];
            pre_q <= reg_wdata[DIV_W];
        end
    end

    // Command word: load on accepted write, shift in read samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (start) begin
            data_q <= reg_wdata;
        end else if (smp_valid) begin
            data_q[15:0] <= {data_q[14:0], smp_bit};
        end
    end

    // Read mux for the two register words.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CTRL)
            reg_rdata[DIV_W+1:0] = {busy, pre_q, div_q};
        else if (reg_addr == OFS_CMD)
            reg_rdata = data_q;
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pre_en    (pre_q),
        .cmd       (reg_wdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .active    (busy),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .smp_valid (smp_valid),
        .smp_bit   (smp_bit)
    );
endmodule

// File: rtl/mdio_master_checks.sv
// Module: protocol checker bound to the management master.
// Watches the line, clock and command word for timing rule violations.
module mdio_master_checks
    import mdio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mdc,
    input logic              mdio_out,
    input logic              mdio_oe,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  data_q
);
    // R3: management clock parked low while no frame runs
    a_r3_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R6: line output and enable hold while mdc stays high
    a_r6_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    // R8: line released once busy drops
    a_r8_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !mdio_oe);

    // R9: command write during busy leaves the command word alone
    a_r9_ignore_busy_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == OFS_CMD) |=> $stable(data_q[31:16]));

    // R8: the clock never runs ahead of busy
    a_r8_mdc_rise_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);
endmodule

bind mdio_master mdio_master_checks u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .data_q   (data_q)
);

// File: tb/mdio_master_bench.sv
// Bench: scoreboard around a PHY model. The driver pushes the expected
// frame into a queue; the monitor captures line bits at mdc rises and
// compares when busy drops.
module mdio_master_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] cmd;
        logic        pre;
        logic [6:0]  div;
        logic [15:0] phy;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    item_t       q[$];
    logic [63:0] cap, oecap;
    int          nbits = 0;
    int          run = 0;
    logic        per_bad = 1'b0;
    logic        prev_busy = 1'b0;
    logic        prev_mdc = 1'b0;
    logic        busy_s;

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, pa, ra, 2'b10, d};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        do rd(3'h0, c); while (c[8]);
    endtask

    // Driver: push expected item and start the frame.
    task automatic do_cmd(input logic [31:0] cmd, input logic pre,
                          input logic [6:0] div, input logic [15:0] phy);
        item_t it;
        wait_idle();
        wr(3'h0, {24'h0, pre, div});
        it.cmd = cmd; it.pre = pre; it.div = div; it.phy = phy;
        q.push_back(it);
        wr(3'h4, cmd);
    endtask

    // Capture line value and enable at each mdc rise.
    always @(posedge mdc) begin
        cap   = {cap[62:0], (mdio_oe ? mdio_out : mdio_in)};
        oecap = {oecap[62:0], mdio_oe};
        nbits++;
    end

    // PHY model: present the next bit after each mdc fall.
    always @(negedge mdc) begin
        if (q.size() > 0 && q[0].cmd[29:28] == 2'b10) begin
            int pos;
            pos = nbits - (q[0].pre ? 32 : 0);
            if (pos == 14)                 mdio_in = 1'b1;
            else if (pos == 15)            mdio_in = 1'b0;
            else if (pos >= 16 && pos < 32) mdio_in = q[0].phy[31-pos];
            else                           mdio_in = 1'b1;
        end
    end

    // Monitor: half-period timing and frame comparison at busy fall.
    assign busy_s = u_mdio_master.reg_rdata[8] | 1'b0;
    always @(negedge clk) begin
        logic b;
        cycles++;
        b = (q.size() > 0) && (mdc || prev_mdc || run > 0 || prev_busy);
        if (!prev_busy && mdio_oe) begin
            nbits = 0; cap = '0; oecap = '0; per_bad = 1'b0; run = 0;
        end
        if (q.size() > 0) begin
            int half;
            half = (q[0].div == 0) ? 2 : q[0].div + 1;
            if (mdc != prev_mdc) begin
                if (run != half) per_bad = 1'b1;
                run = 1;
            end else if (mdio_oe || mdc || run > 0) begin
                run++;
            end
        end
        if (prev_busy && !mdio_oe && !mdc && q.size() > 0 &&
            (nbits == 32 || nbits == 64)) begin
            item_t it;
            int len;
            logic [63:0] eb, eo;
            it = q.pop_front();
            len = it.pre ? 64 : 32;
            if (it.cmd[29:28] == 2'b10) begin
                eb = {32'hFFFF_FFFF, it.cmd[31:16], it.phy};
                eo = {32'hFFFF_FFFF, 14'h3FFF, 18'h0};
            end else begin
                eb = {32'hFFFF_FFFF, it.cmd};
                eo = '1;
            end
            if (!it.pre) begin eb[63:32] = '0; eo[63:32] = '0; end
            check("R4/R5 frame bits and length", {cap[63:0] & (it.pre ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF), 57'h0, 7'(nbits)} == {eb, 57'h0, 7'(len)} ? 64'd1 : 64'd0, 64'd1);
            check("R7 line release pattern", oecap & (it.pre ? '1 : 64'hFFFF_FFFF), eo);
            check("R3 mdc half period", {63'h0, per_bad}, 64'd0);
            run = 0;
        end
        prev_busy = mdio_oe || (prev_busy && (mdc || nbits % 32 != 0));
        prev_mdc  = mdc;
        if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(3'h0, d);
        check("R1 control after reset", d, 0);
        check("R1 mdc after reset", mdc, 0);
        check("R1 oe after reset", mdio_oe, 0);
        // R2: field readback, busy bit ignores writes
        wr(3'h0, 32'hFFFF_FFFF);
        rd(3'h0, d);
        check("R2 control readback", d, 32'h0000_00FF);
        wr(3'h0, 32'h0000_0155);
        rd(3'h0, d);
        check("R2 control readback 2", d, 32'h0000_0055);
        // R4 R5: write frame with preamble
        do_cmd(mk(2'b01, 5'd5, 5'd3, 16'hA5C3), 1'b1, 7'd2, 16'h0);
        // R8: busy visible while running
        rd(3'h0, d);
        check("R8 busy while frame runs", d[8], 1);
        // R7: read frame with preamble
        do_cmd(mk(2'b10, 5'd17, 5'd30, 16'h0), 1'b1, 7'd3, 16'h9E71);
        wait_idle();
        rd(3'h4, d);
        check("R7 read data word", d, {mk(2'b10, 5'd17, 5'd30, 16'h0)}[31:16] == d[31:16] ? {d[31:16], 16'h9E71} : 32'hX);
        check("R7 read data low half", d[15:0], 16'h9E71);
        // R3 R4: divider zero acts as one, no preamble
        do_cmd(mk(2'b01, 5'd31, 5'd0, 16'h8001), 1'b0, 7'd0, 16'h0);
        // R7: read without preamble, typical divider
        do_cmd(mk(2'b10, 5'd1, 5'd2, 16'h0), 1'b0, 7'd26, 16'h3C5A);
        wait_idle();
        rd(3'h4, d);
        check("R7 read no preamble", d[15:0], 16'h3C5A);
        // R9: command during busy ignored
        c1 = mk(2'b01, 5'd9, 5'd12, 16'h1234);
        do_cmd(c1, 1'b0, 7'd1, 16'h0);
        repeat (20) @(negedge clk);
        wr(3'h4, mk(2'b10, 5'd2, 5'd2, 16'hFFFF));
        rd(3'h4, d);
        check("R9 command word during busy", d, c1);
        wait_idle();
        rd(3'h4, d);
        check("R9 command word after frame", d, c1);
        // R8: line released and mdc low after frame
        check("R8 oe released when idle", mdio_oe, 0);
        check("R3 mdc low when idle", mdc, 0);
        repeat (5) @(negedge clk);
        check("R8 scoreboard drained", q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule